// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Summary

The block collects 72 level-sensitive interrupt sources: eight direct sources plus two groups of 32. Each source has an enable bit. A source that is high and enabled becomes pending one clock later, and each group's masked pending word can be read over a small register port. The direct group's read word is also a summary word. Besides the eight direct sources, it holds two cascade flags, one for each wide group, and eleven shortcut flags. The shortcut flags copy frequently used sources from the wide groups, so a handler can often find the cause of an interrupt with a single read.

An interrupt request output is the OR of the summary word. A fast interrupt output follows a single source, picked by a 7-bit index in a control register. The block does not take that source out of the normal request path.

Top module: `icb_banked_ic`

## Requirements
- R1: After reset all enables are clear, the fast-interrupt control register reads 0, and both irq_o and fiq_o are low.
- R2: Enable bits are set and cleared only by writing ones. A write of 1s to the set address of a group ORs those bits into its enable bits, and a write to its clear address clears them. Zero bits in the write leave the enable bits unchanged. Both the set address and the clear address of a group read back its current enable bits. The addresses are: direct set 0x18 / clear 0x24, wide group A set 0x10 / clear 0x1C, wide group B set 0x14 / clear 0x20.
- R3: Reading group A at 0x04 or group B at 0x08 returns source AND enable. It reflects the sources and enables one clock edge after they change.
- R4: Bits 7:0 of the summary word read at 0x00 are the masked direct sources.
- R5: Summary bit 8 (bit 9) is set exactly when some enabled pending source of group A (group B) is not a shortcut source.
- R6: Summary bits 10 to 14 mirror group A sources 7, 9, 10, 18 and 19, and bits 15 to 20 mirror group B sources 21, 22, 23, 24, 25 and 30, each masked by its own group enable. A pending shortcut source also sets its own bit in its group word. It never sets the cascade flag. Summary bits 31:21 read 0.
- R7: Writes to the direct set and clear addresses affect only bits 7:0. They cannot mask or unmask a shortcut or cascade flag.
- R8: irq_o is high exactly when the summary word is nonzero.
- R9: The control register at 0x0C holds a source index in bits 6:0 and an enable flag in bit 7, and bits 31:8 read 0. Index 0-31 selects group A, 32-63 selects group B, and 64-71 selects direct sources 0-7. When the flag is set, fiq_o follows the raw level of the selected source one edge later, independent of its enable bit.
- R10: A source that is both FIQ-selected and IRQ-enabled drives irq_o and fiq_o high together.
- R11: An index of 72 or more never asserts fiq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_d_i | input | 8 | Direct group source levels |
| src_a_i | input | 32 | Wide group A source levels |
| src_b_i | input | 32 | Wide group B source levels |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The fast path and the normal request path can both fire in the same cycle from one source. The bench enables a group B source as an IRQ and also selects it by index for the FIQ. It then raises that source and checks irq_o and fiq_o in the same sampled cycle. It also checks the same source with its IRQ enable clear, where fiq_o must fire without irq_o. In the same way, a shortcut source and a plain source of one group are raised together, and the bench checks that the cascade flag follows only the plain one.

// File: rtl/icb_pkg.sv
package icb_pkg;
  localparam int DW      = 32;
  localparam int AW      = 6;
  localparam int N_D     = 8;
  localparam int N_W     = 32;
  localparam int N_SC_A  = 5;
  localparam int N_SC_B  = 6;
  localparam int SUM_W   = N_D + 2 + N_SC_A + N_SC_B;
  localparam int N_SRC   = 2 * N_W + N_D;
  localparam int IDX_W   = 7;
  localparam int FIQ_EN_BIT = IDX_W;

  localparam logic [AW-1:0] A_SUM    = 6'h00;
  localparam logic [AW-1:0] A_PEND_A = 6'h04;
  localparam logic [AW-1:0] A_PEND_B = 6'h08;
  localparam logic [AW-1:0] A_FIQ    = 6'h0C;
  localparam logic [AW-1:0] A_SET_A  = 6'h10;
  localparam logic [AW-1:0] A_SET_B  = 6'h14;
  localparam logic [AW-1:0] A_SET_D  = 6'h18;
  localparam logic [AW-1:0] A_CLR_A  = 6'h1C;
  localparam logic [AW-1:0] A_CLR_B  = 6'h20;
  localparam logic [AW-1:0] A_CLR_D  = 6'h24;

  function automatic int sc_a_idx(input int k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      default: return 19;
    endcase
  endfunction

  function automatic int sc_b_idx(input int k);
    case (k)
      0: return 21;
      1: return 22;
      2: return 23;
      3: return 24;
      4: return 25;
      default: return 30;
    endcase
  endfunction

  function automatic logic [N_W-1:0] sc_a_mask();
    logic [N_W-1:0] m = '0;
    for (int k = 0; k < N_SC_A; k++) m[sc_a_idx(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [N_W-1:0] sc_b_mask();
    logic [N_W-1:0] m = '0;
    for (int k = 0; k < N_SC_B; k++) m[sc_b_idx(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/icb_en_bank.sv
module icb_en_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (set_we_i)      en_q <= en_q | wdata_i;
      else if (clr_we_i) en_q <= en_q & ~wdata_i;
      pend_q <= src_i & en_q;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

  // R3: nothing pends unless it was enabled the cycle before
  p_pend_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(en_q)) == '0));
endmodule

// File: rtl/icb_summary.sv
module icb_summary
  import icb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_D-1:0]   pend_d_i,
  input  logic [N_W-1:0]   pend_a_i,
  input  logic [N_W-1:0]   pend_b_i,
  output logic [SUM_W-1:0] sum_o
);
  localparam logic [N_W-1:0] SC_A_M = sc_a_mask();
  localparam logic [N_W-1:0] SC_B_M = sc_b_mask();
  localparam int CASC_A = N_D;
  localparam int CASC_B = N_D + 1;
  localparam int SC_A_BASE = N_D + 2;
  localparam int SC_B_BASE = SC_A_BASE + N_SC_A;

  assign sum_o[N_D-1:0] = pend_d_i;
  assign sum_o[CASC_A]  = |(pend_a_i & ~SC_A_M);
  assign sum_o[CASC_B]  = |(pend_b_i & ~SC_B_M);

  for (genvar k = 0; k < N_SC_A; k++) begin : g_sc_a
    assign sum_o[SC_A_BASE+k] = pend_a_i[sc_a_idx(k)];
  end
  for (genvar k = 0; k < N_SC_B; k++) begin : g_sc_b
    assign sum_o[SC_B_BASE+k] = pend_b_i[sc_b_idx(k)];
  end

  // R6: a shortcut flag implies a pending source in its home group
  p_sc_home_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_o[SC_B_BASE-1:SC_A_BASE] != '0) |-> (pend_a_i != '0));
  // R5: a cascade flag implies its group has a pending source
  p_cascade_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o[CASC_B] |-> (pend_b_i != '0));
endmodule

// File: rtl/icb_fiq_sel.sv
module icb_fiq_sel
  import icb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W:0]   ctl_i,
  input  logic [N_SRC-1:0] src_i,
  output logic             fiq_o
);
  localparam int PAD_W = 2 ** IDX_W;
  logic [PAD_W-1:0] src_pad;
  logic             fiq_q;

  assign src_pad = {{(PAD_W-N_SRC){1'b0}}, src_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fiq_q <= 1'b0;
    else         fiq_q <= ctl_i[FIQ_EN_BIT] & src_pad[ctl_i[IDX_W-1:0]];
  end

  assign fiq_o = fiq_q;

  // R9: disabled fast path stays quiet next cycle
  p_fiq_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i[FIQ_EN_BIT] |=> !fiq_o);
  // R11: out-of-range index never fires
  p_fiq_oob_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(ctl_i[IDX_W-1:0]) >= N_SRC) |=> !fiq_o);
endmodule

// File: rtl/icb_banked_ic.sv
module icb_banked_ic
  import icb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    src_d_i,
  input  logic [31:0]   src_a_i,
  input  logic [31:0]   src_b_i,
  input  logic          wr_i,
  input  logic [5:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o,
  output logic          fiq_o
);
  logic [N_D-1:0]   en_d, pend_d;
  logic [N_W-1:0]   en_a, pend_a, en_b, pend_b;
  logic [SUM_W-1:0] sum;
  logic [IDX_W:0]   fiq_ctl_q;

  icb_en_bank #(.W(N_D)) u_bank_d (
    .clk_i, .rst_ni,
    .set_we_i (wr_i && addr_i == A_SET_D),
    .clr_we_i (wr_i && addr_i == A_CLR_D),
    .wdata_i  (wdata_i[N_D-1:0]),
    .src_i    (src_d_i),
    .en_o     (en_d),
    .pend_o   (pend_d)
  );

  icb_en_bank #(.W(N_W)) u_bank_a (
    .clk_i, .rst_ni,
    .set_we_i (wr_i && addr_i == A_SET_A),
    .clr_we_i (wr_i && addr_i == A_CLR_A),
    .wdata_i  (wdata_i),
    .src_i    (src_a_i),
    .en_o     (en_a),
    .pend_o   (pend_a)
  );

  icb_en_bank #(.W(N_W)) u_bank_b (
    .clk_i, .rst_ni,
    .set_we_i (wr_i && addr_i == A_SET_B),
    .clr_we_i (wr_i && addr_i == A_CLR_B),
    .wdata_i  (wdata_i),
    .src_i    (src_b_i),
    .en_o     (en_b),
    .pend_o   (pend_b)
  );

  icb_summary u_sum (
    .clk_i, .rst_ni,
    .pend_d_i (pend_d),
    .pend_a_i (pend_a),
    .pend_b_i (pend_b),
    .sum_o    (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      fiq_ctl_q <= '0;
    else if (wr_i && addr_i == A_FIQ) fiq_ctl_q <= wdata_i[IDX_W:0];
  end

  // index order: group A, group B, direct
  icb_fiq_sel u_fiq (
    .clk_i, .rst_ni,
    .ctl_i (fiq_ctl_q),
    .src_i ({src_d_i, src_b_i, src_a_i}),
    .fiq_o (fiq_o)
  );

  assign irq_o = |sum;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_SUM:             rdata_o[SUM_W-1:0] = sum;
      A_PEND_A:          rdata_o = pend_a;
      A_PEND_B:          rdata_o = pend_b;
      A_FIQ:             rdata_o[IDX_W:0] = fiq_ctl_q;
      A_SET_A, A_CLR_A:  rdata_o = en_a;
      A_SET_B, A_CLR_B:  rdata_o = en_b;
      A_SET_D, A_CLR_D:  rdata_o[N_D-1:0] = en_d;
      default:           rdata_o = '0;
    endcase
  end

  // R8: no enables for a cycle means no request
  p_irq_no_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_d == '0 && en_a == '0 && en_b == '0) |=> !irq_o);
  // R9: control register upper bits read zero
  p_ctl_upper_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_FIQ) |-> (rdata_o[31:8] == '0));
  // R1: reset leaves all enables clear
  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (en_d == '0 && en_a == '0 && en_b == '0));
endmodule

// File: tb/icb_banked_ic_tb.sv
module icb_banked_ic_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_d = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  icb_banked_ic u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_d_i(src_d), .src_a_i(src_a), .src_b_i(src_b),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_all();
    src_d = '0; src_a = '0; src_b = '0;
    wr_reg(6'h24, '1); wr_reg(6'h1C, '1); wr_reg(6'h20, '1); wr_reg(6'h0C, 0);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h18, d); chk(d, 0, "R1 en_d");
    rd(6'h10, d); chk(d, 0, "R1 en_a");
    rd(6'h14, d); chk(d, 0, "R1 en_b");
    rd(6'h0C, d); chk(d, 0, "R1 fiq ctl");
    chk({31'd0, irq}, 0, "R1 irq"); chk({31'd0, fiq}, 0, "R1 fiq");
  endtask

  task automatic t_enable_semantics();
    logic [31:0] d;
    wr_reg(6'h10, 32'h0000_00F0);
    wr_reg(6'h10, 32'h0000_0003);
    rd(6'h10, d); chk(d, 32'h0000_00F3, "R2 set ors");
    wr_reg(6'h1C, 32'h0000_0030);
    rd(6'h1C, d); chk(d, 32'h0000_00C3, "R2 clr readback");
    wr_reg(6'h1C, 32'h0);
    rd(6'h10, d); chk(d, 32'h0000_00C3, "R2 zero write no effect");
    wr_reg(6'h14, 32'hA000_0001);
    rd(6'h20, d); chk(d, 32'hA000_0001, "R2 group B");
    clear_all();
  endtask

  task automatic t_pending();
    logic [31:0] d;
    wr_reg(6'h10, 32'h0000_FFFF);
    wr_reg(6'h14, 32'h0000_0F00);
    src_a = 32'h00FF_00F0; src_b = 32'h0000_3300;
    @(negedge clk); // edge has sampled src -> pend
    rd(6'h04, d); chk(d, 32'h0000_00F0, "R3 group A masked");
    rd(6'h08, d); chk(d, 32'h0000_0300, "R3 group B masked");
    clear_all();
  endtask

  task automatic t_direct();
    logic [31:0] d;
    wr_reg(6'h18, 32'h0000_00A5);
    src_d = 8'hFF; settle();
    rd(6'h00, d); chk(d, 32'h0000_00A5, "R4 direct summary");
    chk({31'd0, irq}, 1, "R8 irq from direct");
    src_d = 8'h00; settle();
    chk({31'd0, irq}, 0, "R8 irq drops");
    clear_all();
  endtask

  task automatic t_cascade_shortcut();
    logic [31:0] d;
    wr_reg(6'h10, '1); wr_reg(6'h14, '1);
    src_a = 32'h0000_0080;          // A7 only: shortcut
    settle();
    rd(6'h00, d); chk(d, 32'h0000_0400, "R6 A7 shortcut no cascade");
    rd(6'h04, d); chk(d, 32'h0000_0080, "R6 A7 home bit");
    src_a = 32'h0000_0081;          // plus A0 plain
    settle();
    rd(6'h00, d); chk(d, 32'h0000_0500, "R5 cascade A with shortcut");
    src_a = 32'h000C_0600; src_b = 32'h4000_0000;
    settle();
    rd(6'h00, d); chk(d, 32'h0010_7800, "R6 A9,A10,A18,A19,B30");
    src_a = '0; src_b = 32'h03E0_0001;
    settle();
    rd(6'h00, d); chk(d, 32'h000F_8200, "R5 R6 B21-25 plus cascade B");
    clear_all();
  endtask

  task automatic t_direct_mask_ignored();
    logic [31:0] d;
    wr_reg(6'h14, 32'h0020_0004);   // B21 shortcut, B2 plain
    src_b = 32'h0020_0004;
    wr_reg(6'h24, '1);              // direct clear all bits
    wr_reg(6'h18, 32'hFFFF_FF00);   // direct set upper bits
    settle();
    rd(6'h00, d); chk(d, 32'h0000_8200, "R7 direct writes keep flags");
    rd(6'h18, d); chk(d, 0, "R7 direct enables unchanged");
    wr_reg(6'h20, 32'h0020_0000);
    settle();
    rd(6'h00, d); chk(d, 32'h0000_0200, "R7 shortcut masked by home group");
    clear_all();
  endtask

  task automatic t_fiq();
    logic [31:0] d;
    wr_reg(6'h0C, 32'hFFFF_FFA3);   // en, index 35 = B3
    rd(6'h0C, d); chk(d, 32'h0000_00A3, "R9 ctl readback");
    src_b = 32'h0000_0008; settle();
    chk({31'd0, fiq}, 1, "R9 fiq B3 without enable");
    chk({31'd0, irq}, 0, "R9 irq stays low");
    src_b = '0; settle();
    chk({31'd0, fiq}, 0, "R9 fiq follows level");
    wr_reg(6'h0C, 32'h0000_00C2);   // index 66 = D2
    src_d = 8'h04; settle();
    chk({31'd0, fiq}, 1, "R9 index 66 direct 2");
    wr_reg(6'h0C, 32'h0000_0042);   // flag off
    settle();
    chk({31'd0, fiq}, 0, "R9 flag off");
    src_d = '0;
    wr_reg(6'h0C, 32'h0000_0080);   // index 0 = A0
    src_a = 32'h1; settle();
    chk({31'd0, fiq}, 1, "R9 index 0 group A");
    clear_all();
  endtask

  task automatic t_fiq_irq_both();
    wr_reg(6'h14, 32'h0000_0008);
    wr_reg(6'h0C, 32'h0000_00A3);
    src_b = 32'h0000_0008; settle();
    chk({30'd0, irq, fiq}, 2'b11, "R10 irq and fiq together");
    clear_all();
  endtask

  task automatic t_fiq_oob();
    wr_reg(6'h0C, 32'h0000_00E4);   // index 100
    src_d = '1; src_a = '1; src_b = '1; settle();
    chk({31'd0, fiq}, 0, "R11 index 100");
    wr_reg(6'h0C, 32'h0000_00C8);   // index 72
    settle();
    chk({31'd0, fiq}, 0, "R11 index 72");
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_semantics();
    t_pending();
    t_direct();
    t_cascade_shortcut();
    t_direct_mask_ignored();
    t_fiq();
    t_fiq_irq_both();
    t_fiq_oob();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule